// File: doc/BRIEF.md
# Transmit Channel Interrupt Status

This block turns the FIFO status of one audio transmit channel into interrupt status. It keeps a raw status word with three sources: a sticky underrun condition, a half-empty request for more samples, and a transmit-complete indication that the channel is idle with nothing left to send. The status word is refreshed only when a refresh is requested. A refresh happens on the recompute strobe, which the surrounding logic raises after any host register write or codec data request. A write to the interrupt-clear register also causes a refresh.

A host-written enable word masks the raw status. The interrupt line is registered and goes high when any enabled status bit is set. The raw status is also offered as a seven-bit all-interrupts read view. The underrun flag itself lives in the FIFO. When the host writes the clear register with the underrun-clear bit set, this block sends the FIFO a one-cycle clear pulse. In that same refresh it reports underrun as cleared, even if the FIFO flag has not yet dropped.

Top module: `txirq_status`

## Requirements
- R1: After reset, rawStatus is all zero, irqLine is 0 and underrunClrPulse is 0.
- R2: On a refresh (statusUpdate or clrWrite high at a clock edge), rawStatus bit 0 (underrun) takes the value of fifoUnderrun from that edge, unless R8 applies.
- R3: On a refresh, rawStatus bit 1 (half-empty request) takes the value of fifoHalfEmpty.
- R4: On a refresh, rawStatus bit 2 (transmit complete) becomes 1 only when chanBusy is 0 and fifoEmpty is 1; otherwise it becomes 0.
- R5: Without a refresh, rawStatus keeps its value whatever the FIFO flags do.
- R6: irqLine, one clock after an edge, equals the OR of (rawStatus AND irqEnable) as they stood at that edge.
- R7: allIntsView always equals rawStatus bits 6 down to 0.
- R8: A clrWrite with clrData bit 0 set raises underrunClrPulse for exactly the next cycle and forces rawStatus bit 0 to 0 in that refresh, even when fifoUnderrun is 1 or statusUpdate is also high.
- R9: A clrWrite with clrData bit 0 clear produces no pulse. It still refreshes rawStatus.
- R10: rawStatus bits 3 and above are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| statusUpdate | input | 1 | Refresh request after a register write or codec data request |
| fifoUnderrun | input | 1 | Sticky underrun flag held by the FIFO |
| fifoHalfEmpty | input | 1 | FIFO is at or below half full |
| fifoEmpty | input | 1 | FIFO holds no samples |
| chanBusy | input | 1 | Channel is still shifting out a frame |
| irqEnable | input | STAT_W | Host interrupt enable word |
| clrWrite | input | 1 | Write strobe of the interrupt-clear register |
| clrData | input | CLR_W | Data written to the interrupt-clear register |
| rawStatus | output | STAT_W | Raw interrupt status |
| allIntsView | output | VIEW_W | All-interrupts read view |
| irqLine | output | 1 | Registered, masked interrupt line |
| underrunClrPulse | output | 1 | One-cycle clear request to the FIFO underrun flag |

## Verification
Two functions can land on the same edge: a refresh that samples a still-high fifoUnderrun, and an underrun clear. The bench provokes this by asserting clrWrite with bit 0 set, together with statusUpdate, while fifoUnderrun stays 1. It expects rawStatus bit 0 to read 0 and underrunClrPulse to be high on the following cycle. A second collision is between an enable change and a status change on the same edge. The scoreboard judges that case by comparing irqLine one cycle later with the OR of the status and enable values taken at that edge.

// File: rtl/txirq_pkg.sv
package txirq_pkg;
  // Status bit positions; the host decodes these.
  localparam int BIT_UNDERRUN  = 0;
  localparam int BIT_HALFEMPTY = 1;
  localparam int BIT_COMPLETE  = 2;
  localparam int NUM_SOURCES   = 3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic recompute;     // refresh the status word this edge
    logic clearUnderrun; // report underrun as cleared this edge
  } irqStrobes_t;
endpackage

// File: rtl/txirq_ctrl.sv
module txirq_ctrl
  import txirq_pkg::*;
#(
  parameter int CLR_W   = 8,
  parameter int CLR_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             statusUpdate,
  input  logic             clrWrite,
  input  logic [CLR_W-1:0] clrData,
  output irqStrobes_t      strobes,
  output logic             underrunClrPulse
);
  logic clrHit;

  always_comb begin
    clrHit                = clrWrite && clrData[CLR_BIT];
    strobes.recompute     = statusUpdate || clrWrite;
    strobes.clearUnderrun = clrHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) underrunClrPulse <= 1'b0;
    else        underrunClrPulse <= clrHit;
  end
endmodule

// File: rtl/txirq_datapath.sv
module txirq_datapath
  import txirq_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter int VIEW_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irqStrobes_t       strobes,
  input  logic              fifoUnderrun,
  input  logic              fifoHalfEmpty,
  input  logic              fifoEmpty,
  input  logic              chanBusy,
  input  logic [STAT_W-1:0] irqEnable,
  output logic [STAT_W-1:0] rawStatus,
  output logic [VIEW_W-1:0] allIntsView,
  output logic              irqLine
);
  logic [STAT_W-1:0] srcBits;
  logic [STAT_W-1:0] statusQ;
  logic              irqQ;

  always_comb begin
    srcBits                = '0;
    srcBits[BIT_UNDERRUN]  = fifoUnderrun && !strobes.clearUnderrun;
    srcBits[BIT_HALFEMPTY] = fifoHalfEmpty;
    srcBits[BIT_COMPLETE]  = fifoEmpty && !chanBusy;
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (b < NUM_SOURCES) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 statusQ[b] <= 1'b0;
        else if (strobes.recompute) statusQ[b] <= srcBits[b];
      end
    end else begin : g_tie
      assign statusQ[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqQ <= 1'b0;
    else        irqQ <= |(statusQ & irqEnable);
  end

  assign rawStatus   = statusQ;
  assign allIntsView = statusQ[VIEW_W-1:0];
  assign irqLine     = irqQ;
endmodule

// File: rtl/txirq_status.sv
module txirq_status
  import txirq_pkg::*;
#(
  parameter int STAT_W  = 8,
  parameter int VIEW_W  = 7,
  parameter int CLR_W   = 8,
  parameter int CLR_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              statusUpdate,
  input  logic              fifoUnderrun,
  input  logic              fifoHalfEmpty,
  input  logic              fifoEmpty,
  input  logic              chanBusy,
  input  logic [STAT_W-1:0] irqEnable,
  input  logic              clrWrite,
  input  logic [CLR_W-1:0]  clrData,
  output logic [STAT_W-1:0] rawStatus,
  output logic [VIEW_W-1:0] allIntsView,
  output logic              irqLine,
  output logic              underrunClrPulse
);
  irqStrobes_t strobes;

  txirq_ctrl #(.CLR_W(CLR_W), .CLR_BIT(CLR_BIT)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .statusUpdate(statusUpdate),
    .clrWrite(clrWrite), .clrData(clrData),
    .strobes(strobes), .underrunClrPulse(underrunClrPulse)
  );

  txirq_datapath #(.STAT_W(STAT_W), .VIEW_W(VIEW_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .fifoUnderrun(fifoUnderrun), .fifoHalfEmpty(fifoHalfEmpty),
    .fifoEmpty(fifoEmpty), .chanBusy(chanBusy), .irqEnable(irqEnable),
    .rawStatus(rawStatus), .allIntsView(allIntsView), .irqLine(irqLine)
  );
endmodule

// File: rtl/txirq_status_chk.sv
module txirq_status_chk #(
  parameter int STAT_W  = 8,
  parameter int CLR_W   = 8,
  parameter int CLR_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              statusUpdate,
  input logic              fifoUnderrun,
  input logic              fifoHalfEmpty,
  input logic              fifoEmpty,
  input logic              chanBusy,
  input logic [STAT_W-1:0] irqEnable,
  input logic              clrWrite,
  input logic [CLR_W-1:0]  clrData,
  input logic [STAT_W-1:0] rawStatus,
  input logic              irqLine,
  input logic              underrunClrPulse
);
  assert_underrun_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (statusUpdate || clrWrite) && !(clrWrite && clrData[CLR_BIT])
      |=> rawStatus[0] == $past(fifoUnderrun));

  assert_half_empty_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (statusUpdate || clrWrite) |=> rawStatus[1] == $past(fifoHalfEmpty));

  assert_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (statusUpdate || clrWrite) |=> rawStatus[2] == $past(fifoEmpty && !chanBusy));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!statusUpdate && !clrWrite) |=> $stable(rawStatus));

  assert_irq_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irqLine == $past(|(rawStatus & irqEnable)));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clrWrite && clrData[CLR_BIT]) |=> (underrunClrPulse && !rawStatus[0]));

  assert_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(clrWrite && clrData[CLR_BIT]) |=> !underrunClrPulse);

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rawStatus >> 3) == '0);
endmodule

bind txirq_status txirq_status_chk #(.STAT_W(STAT_W), .CLR_W(CLR_W), .CLR_BIT(CLR_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .statusUpdate(statusUpdate),
  .fifoUnderrun(fifoUnderrun), .fifoHalfEmpty(fifoHalfEmpty),
  .fifoEmpty(fifoEmpty), .chanBusy(chanBusy), .irqEnable(irqEnable),
  .clrWrite(clrWrite), .clrData(clrData), .rawStatus(rawStatus),
  .irqLine(irqLine), .underrunClrPulse(underrunClrPulse)
);

// File: tb/txirq_status_tb.sv
module txirq_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STAT_W = 8;
  localparam int VIEW_W = 7;
  localparam int CLR_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic statusUpdate = 1'b0, fifoUnderrun = 1'b0, fifoHalfEmpty = 1'b0;
  logic fifoEmpty = 1'b0, chanBusy = 1'b0, clrWrite = 1'b0;
  logic [STAT_W-1:0] irqEnable = '0;
  logic [CLR_W-1:0]  clrData = '0;
  logic [STAT_W-1:0] rawStatus;
  logic [VIEW_W-1:0] allIntsView;
  logic irqLine, underrunClrPulse;

  int errors = 0;
  int checks = 0;

  typedef struct {
    string             tag;
    logic [STAT_W-1:0] stat;
    logic              irq;
    logic              pulse;
  } expItem_t;
  expItem_t expQ[$];

  logic [STAT_W-1:0] mStat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txirq_status dut_i (
    .clk(clk), .rst_n(rst_n), .statusUpdate(statusUpdate),
    .fifoUnderrun(fifoUnderrun), .fifoHalfEmpty(fifoHalfEmpty),
    .fifoEmpty(fifoEmpty), .chanBusy(chanBusy), .irqEnable(irqEnable),
    .clrWrite(clrWrite), .clrData(clrData), .rawStatus(rawStatus),
    .allIntsView(allIntsView), .irqLine(irqLine),
    .underrunClrPulse(underrunClrPulse)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the outcome expected after the edge.
  task automatic step(string tag, bit upd, bit und, bit he, bit emp, bit busy,
                      logic [STAT_W-1:0] en, bit cw, logic [CLR_W-1:0] cd);
    expItem_t it;
    bit clr, rec;
    @(negedge clk);
    statusUpdate = upd; fifoUnderrun = und; fifoHalfEmpty = he;
    fifoEmpty = emp; chanBusy = busy; irqEnable = en; clrWrite = cw; clrData = cd;
    clr = cw && cd[0];
    rec = upd || cw;
    it.tag   = tag;
    it.irq   = |(mStat & en);
    it.pulse = clr;
    it.stat  = rec ? {{(STAT_W-3){1'b0}}, (emp && !busy), he, (und && !clr)} : mStat;
    mStat    = it.stat;
    expQ.push_back(it);
  endtask

  // Monitor: compares the design against queued expectations after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(it.tag, "rawStatus", 32'(rawStatus), 32'(it.stat));
        check("R7", "allIntsView", 32'(allIntsView), 32'(it.stat[VIEW_W-1:0]));
        check(it.tag, "irqLine", 32'(irqLine), 32'(it.irq));
        check(it.tag, "underrunClrPulse", 32'(underrunClrPulse), 32'(it.pulse));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    check("R1", "rawStatus", 32'(rawStatus), 32'h0);
    check("R1", "irqLine", 32'(irqLine), 32'h0);
    check("R1", "underrunClrPulse", 32'(underrunClrPulse), 32'h0);
    rst_n = 1'b1;

    // R2/R3/R4: each source alone, enables all on
    step("R2", 1, 1, 0, 0, 1, 8'hFF, 0, 8'h00);
    step("R3", 1, 0, 1, 0, 1, 8'hFF, 0, 8'h00);
    step("R4", 1, 0, 0, 1, 0, 8'hFF, 0, 8'h00);
    step("R4", 1, 0, 0, 1, 1, 8'hFF, 0, 8'h00);   // busy blocks complete
    step("R4", 1, 0, 0, 0, 0, 8'hFF, 0, 8'h00);   // not empty blocks complete
    // R5: flags change with no refresh
    step("R5", 1, 1, 1, 1, 0, 8'h00, 0, 8'h00);
    step("R5", 0, 0, 0, 0, 1, 8'h00, 0, 8'h00);
    step("R5", 0, 1, 0, 1, 1, 8'h00, 0, 8'h00);
    // R6: enable masking, single bits
    step("R6", 0, 0, 0, 0, 0, 8'h01, 0, 8'h00);
    step("R6", 0, 0, 0, 0, 0, 8'h02, 0, 8'h00);
    step("R6", 0, 0, 0, 0, 0, 8'h78, 0, 8'h00);
    step("R6", 1, 0, 1, 0, 1, 8'h04, 0, 8'h00);   // status and enable change together
    step("R6", 0, 0, 0, 0, 0, 8'h02, 0, 8'h00);
    step("R6", 0, 0, 0, 0, 0, 8'h02, 0, 8'h00);
    // R8: clear with underrun still raised, with and without statusUpdate
    step("R2", 1, 1, 0, 0, 1, 8'h01, 0, 8'h00);
    step("R8", 1, 1, 0, 0, 1, 8'h01, 1, 8'h01);
    step("R8", 0, 1, 0, 0, 1, 8'h01, 0, 8'h00);
    step("R8", 0, 1, 1, 0, 1, 8'h01, 1, 8'hFF);
    // R9: clear write without bit 0 refreshes but does not pulse
    step("R9", 0, 1, 0, 1, 0, 8'h07, 1, 8'hFE);
    step("R9", 0, 0, 0, 0, 0, 8'h07, 0, 8'h00);
    // R10: upper status bits stay zero under full stimulus
    step("R10", 1, 1, 1, 1, 0, 8'hFF, 0, 8'h00);
    step("R10", 0, 0, 0, 0, 0, 8'hFF, 0, 8'h00);

    while (expQ.size() != 0) @(posedge clk);
    #2;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule